// File: doc/BRIEF.md
# Table-Driven Microcode Opcode Decoder

This block turns an 8-bit opcode into a microcode fetch by walking a chain of lookup tables that a loader fills at run time. The opcode indexes a 256-entry descriptor table directly. The descriptor it lands on is packed. Its low field names a fast control row. Its high field names an optional slow program row. The fast row also selects a block of eight consecutive datapath lane words. A descriptor of zero means that the opcode is not enabled in the loaded table set. In that case the block raises an illegal flag and fetches nothing.

The parameter `SPLIT` picks between two layouts. The split layout has a 256-row fast control table and a 256-row slow control table. The single layout has one 128-row control table, and the high descriptor field is passed out only as a slow-program index. A one-bit payload-mode input rides along with each lookup to the outputs. It leaves opcode membership unchanged.

Top module: `mcode_decoder`

## Requirements
- R1: The descriptor used for a lookup is entry number `opcode` of the descriptor table, with no other translation.
- R2: A zero descriptor gives a one-cycle `outIllegal` pulse. In that cycle `outValid` is low and the rows, the control words, `outSlowValid` and every lane word are zero.
- R3: With `SPLIT=1`, descriptor bits [7:0] are the fast row and bits [15:8] are the slow row. For example, 0x3010 gives fast row 16 and slow row 48.
- R4: With `SPLIT=1`, a slow row of 0 gives `outSlowValid`=0 and `outSlowWord`=0. A nonzero slow row gives `outSlowValid`=1 and the slow-table word at that row.
- R5: With `SPLIT=0`, bits [6:0] are the control row and bits [13:7] are the slow index. For example, 0x09CF gives row 79 and index 19. `outSlowValid` is high when the index is nonzero, and `outSlowWord` is always zero.
- R6: Lane i, at `outLanes[i*LANE_W +: LANE_W]`, is datapath word `fastRow*8+i`. The slow row never takes part in this address.
- R7: Results appear after the second rising edge, counting the edge that samples `opValid`. One lookup can be accepted on every cycle.
- R8: The write port stores `wrData` into the table picked by `wrSel`, at row `wrAddr`. The selector values are 0 for descriptors, 1 for fast control, 2 for slow control and 3 for lane words. Descriptor bits beyond those kept (bit 15 and up when split, bit 14 and up when single) are dropped.
- R9: A write takes effect only after the edge that performs it. A lookup whose descriptor read or row read shares that edge sees the old contents.
- R10: Reset clears every descriptor, so every opcode is illegal. Reset also sets all outputs to zero, which leaves the reported row at the idle row 0.
- R11: `outSat` equals the `satMode` value that was sampled together with the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | Opcode strobe |
| opcode | input | 8 | Raw opcode |
| satMode | input | 1 | Payload mode carried with the lookup |
| wrEn | input | 1 | Loader write enable |
| wrSel | input | 2 | Target table |
| wrAddr | input | ADDR_W | Row address within the target table |
| wrData | input | WR_W | Word to store |
| outValid | output | 1 | Legal lookup result valid |
| outIllegal | output | 1 | Lookup hit a zero descriptor |
| outSat | output | 1 | Payload mode of this result |
| outFastRow | output | 8 | Decoded fast/control row |
| outSlowRow | output | 8 | Decoded slow row or slow index |
| outSlowValid | output | 1 | Slow row/index is nonzero |
| outFastWord | output | CTRL_W | Fast control word |
| outSlowWord | output | CTRL_W | Slow control word |
| outLanes | output | LANES*LANE_W | Eight datapath lane words |

## Verification
The bench builds two instances side by side. One uses `SPLIT=1`, which covers the 16-bit descriptor decode, the slow-table fetch and the full 2048-word lane table. The other uses `SPLIT=0`, which covers the 7/7-bit decode, the 128-row control table and the rule that no slow word is ever issued. Both instances share 32-bit control and lane words and the eight lanes. Against these two builds the bench checks the row-boundary descriptors, the dropped high descriptor bits, back-to-back lookups, and writes that land on the same edge as a lookup.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

  typedef enum logic [1:0] {
    SEL_OPC  = 2'd0,
    SEL_FAST = 2'd1,
    SEL_SLOW = 2'd2,
    SEL_LANE = 2'd3
  } tblSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic take;    // capture descriptor for the incoming opcode
    logic fetch;   // load output registers from the tables
    logic squash;  // clear output registers (illegal opcode)
    logic wrOpc;
    logic wrFast;
    logic wrSlow;
    logic wrLane;
  } mcdStrobe_t;

endpackage

// File: rtl/mcd_ctrl.sv
module mcd_ctrl
  import mcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       opValid,
  input  logic       satMode,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic       descZero,
  output mcdStrobe_t strobe,
  output logic       outValid,
  output logic       outIllegal,
  output logic       outSat
);

  logic s1Valid;
  logic s1Sat;

  always_comb begin
    strobe        = '0;
    strobe.take   = opValid;
    strobe.fetch  = s1Valid & ~descZero;
    strobe.squash = s1Valid & descZero;
    if (wrEn) begin
      case (tblSel_e'(wrSel))
        SEL_OPC:  strobe.wrOpc  = 1'b1;
        SEL_FAST: strobe.wrFast = 1'b1;
        SEL_SLOW: strobe.wrSlow = 1'b1;
        default:  strobe.wrLane = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid    <= 1'b0;
      s1Sat      <= 1'b0;
      outValid   <= 1'b0;
      outIllegal <= 1'b0;
      outSat     <= 1'b0;
    end else begin
      s1Valid    <= opValid;
      s1Sat      <= satMode;
      outValid   <= s1Valid & ~descZero;
      outIllegal <= s1Valid & descZero;
      outSat     <= s1Sat;
    end
  end

  // R7: every accepted opcode yields a result two cycles later
  p_accept_to_result_r7: assert property (@(posedge clk) disable iff (rst)
    opValid |-> ##2 (outValid || outIllegal));

endmodule

// File: rtl/mcd_store.sv
module mcd_store
  import mcd_pkg::*;
#(
  parameter int SPLIT  = 1,
  parameter int CTRL_W = 32,
  parameter int LANE_W = 32,
  parameter int LANES  = 8,
  parameter int WR_W   = 64,
  parameter int ADDR_W = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  mcdStrobe_t              strobe,
  input  logic [7:0]              opcode,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [WR_W-1:0]         wrData,
  output logic                    descZero,
  output logic [7:0]              outFastRow,
  output logic [7:0]              outSlowRow,
  output logic                    outSlowValid,
  output logic [CTRL_W-1:0]       outFastWord,
  output logic [CTRL_W-1:0]       outSlowWord,
  output logic [LANES*LANE_W-1:0] outLanes
);

  localparam int ROW_W     = (SPLIT != 0) ? 8 : 7;
  localparam int SLOW_W    = (SPLIT != 0) ? 8 : 7;
  localparam int KEEP_W    = ROW_W + SLOW_W;
  localparam int OPC_N     = 256;
  localparam int CTRL_ROWS = 1 << ROW_W;
  localparam int LANE_AW   = $clog2(LANES);
  localparam int DP_AW     = ROW_W + LANE_AW;
  localparam int DP_DEPTH  = CTRL_ROWS * LANES;

  logic unusedWrBits;
  assign unusedWrBits = ^{wrData, strobe.wrSlow};

  // Descriptor table, cleared by reset
  logic [KEEP_W-1:0] opcMem [OPC_N];
  logic [KEEP_W-1:0] descQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < OPC_N; i++) opcMem[i] <= '0;
      descQ <= '0;
    end else begin
      if (strobe.wrOpc && ((wrAddr >> 8) == '0))
        opcMem[wrAddr[7:0]] <= wrData[KEEP_W-1:0];
      if (strobe.take)
        descQ <= opcMem[opcode];
    end
  end

  logic [ROW_W-1:0]  fastRow;
  logic [SLOW_W-1:0] slowRow;
  assign fastRow  = descQ[ROW_W-1:0];
  assign slowRow  = descQ[KEEP_W-1:ROW_W];
  assign descZero = (descQ == '0);

  // Fast (or sole) control table
  logic [CTRL_W-1:0] fastMem [CTRL_ROWS];
  always_ff @(posedge clk) begin
    if (strobe.wrFast && ((wrAddr >> ROW_W) == '0))
      fastMem[wrAddr[ROW_W-1:0]] <= wrData[CTRL_W-1:0];
  end

  // Slow control table only in the split layout
  logic [CTRL_W-1:0] slowRd;
  generate
    if (SPLIT != 0) begin : g_slow
      logic [CTRL_W-1:0] slowMem [1 << SLOW_W];
      always_ff @(posedge clk) begin
        if (strobe.wrSlow && ((wrAddr >> SLOW_W) == '0))
          slowMem[wrAddr[SLOW_W-1:0]] <= wrData[CTRL_W-1:0];
      end
      assign slowRd = slowMem[slowRow];
    end else begin : g_noslow
      assign slowRd = '0;
    end
  endgenerate

  // Datapath lane table, keyed by fast row only
  logic [LANE_W-1:0] dpMem [DP_DEPTH];
  always_ff @(posedge clk) begin
    if (strobe.wrLane && ((wrAddr >> DP_AW) == '0))
      dpMem[wrAddr[DP_AW-1:0]] <= wrData[LANE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.squash) begin
      outFastRow   <= '0;
      outSlowRow   <= '0;
      outSlowValid <= 1'b0;
      outFastWord  <= '0;
      outSlowWord  <= '0;
    end else if (strobe.fetch) begin
      outFastRow   <= 8'(fastRow);
      outSlowRow   <= 8'(slowRow);
      outSlowValid <= (slowRow != '0);
      outFastWord  <= fastMem[fastRow];
      outSlowWord  <= (slowRow != '0) ? slowRd : '0;
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam logic [LANE_AW-1:0] LIDX = LANE_AW'(g);
      logic [LANE_W-1:0] laneQ;
      always_ff @(posedge clk) begin
        if (rst || strobe.squash) laneQ <= '0;
        else if (strobe.fetch)    laneQ <= dpMem[{fastRow, LIDX}];
      end
      assign outLanes[g*LANE_W +: LANE_W] = laneQ;
    end
  endgenerate

  // R4: no slow word leaves the block without a slow row behind it
  p_slow_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !outSlowValid |-> (outSlowWord == '0));

  generate
    if (SPLIT == 0) begin : g_single_chk
      // R5: single-table layout never issues a slow word
      p_no_slow_word_r5: assert property (@(posedge clk) disable iff (rst)
        (outSlowValid || !outSlowValid) |-> (outSlowWord == '0));
    end
  endgenerate

endmodule

// File: rtl/mcode_decoder.sv
module mcode_decoder
  import mcd_pkg::*;
#(
  parameter int SPLIT  = 1,
  parameter int CTRL_W = 32,
  parameter int LANE_W = 32,
  parameter int LANES  = 8,
  parameter int WR_W   = 64,
  parameter int ADDR_W = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    opValid,
  input  logic [7:0]              opcode,
  input  logic                    satMode,
  input  logic                    wrEn,
  input  logic [1:0]              wrSel,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [WR_W-1:0]         wrData,
  output logic                    outValid,
  output logic                    outIllegal,
  output logic                    outSat,
  output logic [7:0]              outFastRow,
  output logic [7:0]              outSlowRow,
  output logic                    outSlowValid,
  output logic [CTRL_W-1:0]       outFastWord,
  output logic [CTRL_W-1:0]       outSlowWord,
  output logic [LANES*LANE_W-1:0] outLanes
);

  mcdStrobe_t strobe;
  logic       descZero;

  mcd_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .opValid   (opValid),
    .satMode   (satMode),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .descZero  (descZero),
    .strobe    (strobe),
    .outValid  (outValid),
    .outIllegal(outIllegal),
    .outSat    (outSat)
  );

  mcd_store #(
    .SPLIT (SPLIT),
    .CTRL_W(CTRL_W),
    .LANE_W(LANE_W),
    .LANES (LANES),
    .WR_W  (WR_W),
    .ADDR_W(ADDR_W)
  ) u_store (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .opcode      (opcode),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .descZero    (descZero),
    .outFastRow  (outFastRow),
    .outSlowRow  (outSlowRow),
    .outSlowValid(outSlowValid),
    .outFastWord (outFastWord),
    .outSlowWord (outSlowWord),
    .outLanes    (outLanes)
  );

  // R2: an illegal result carries no microcode
  p_illegal_empty_r2: assert property (@(posedge clk) disable iff (rst)
    outIllegal |-> (!outValid && !outSlowValid && outFastWord == '0 && outLanes == '0));

  // R7: no result without an opcode strobe two cycles earlier
  p_result_has_cause_r7: assert property (@(posedge clk) disable iff (rst)
    (outValid || outIllegal) |-> $past(opValid, 2));

  // R11: payload mode travels with its lookup
  p_sat_follows_r11: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outSat == $past(satMode, 2)));

endmodule

// File: tb/mcode_decoder_tb_top.sv
`timescale 1ns/1ps
module mcode_decoder_tb_top;

  localparam int LW = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic        opValidS = 0, opValidG = 0;
  logic [7:0]  opcodeS = 0, opcodeG = 0;
  logic        satMode = 0;
  logic        wrEnS = 0, wrEnG = 0;
  logic [1:0]  wrSel = 0;
  logic [10:0] wrAddr = 0;
  logic [63:0] wrData = 0;

  logic vS, iS, sS, svS, vG, iG, sG, svG;
  logic [7:0] frS, srS, frG, srG;
  logic [31:0] fwS, swS, fwG, swG;
  logic [8*LW-1:0] lnS, lnG;

  mcode_decoder #(.SPLIT(1)) dut_i (
    .clk(clk), .rst(rst), .opValid(opValidS), .opcode(opcodeS), .satMode(satMode),
    .wrEn(wrEnS), .wrSel(wrSel), .wrAddr(wrAddr), .wrData(wrData),
    .outValid(vS), .outIllegal(iS), .outSat(sS), .outFastRow(frS), .outSlowRow(srS),
    .outSlowValid(svS), .outFastWord(fwS), .outSlowWord(swS), .outLanes(lnS));

  mcode_decoder #(.SPLIT(0)) dutSingle_i (
    .clk(clk), .rst(rst), .opValid(opValidG), .opcode(opcodeG), .satMode(satMode),
    .wrEn(wrEnG), .wrSel(wrSel), .wrAddr(wrAddr), .wrData(wrData),
    .outValid(vG), .outIllegal(iG), .outSat(sG), .outFastRow(frG), .outSlowRow(srG),
    .outSlowValid(svG), .outFastWord(fwG), .outSlowWord(swG), .outLanes(lnG));

  // {opcode, descriptor, expected row, expected slow}
  localparam logic [55:0] VEC_S [6] = '{
    {8'd65,  32'h0000_3010, 8'd16,  8'd48},
    {8'd48,  32'h0000_0008, 8'd8,   8'd0},
    {8'd70,  32'h0000_00FF, 8'd255, 8'd0},
    {8'd227, 32'h0000_FF01, 8'd1,   8'd255},
    {8'd102, 32'h0000_0100, 8'd0,   8'd1},
    {8'd240, 32'h0000_2A07, 8'd7,   8'd42}
  };
  localparam logic [55:0] VEC_G [4] = '{
    {8'd102, 32'h0000_09CF, 8'd79,  8'd19},
    {8'd65,  32'h0000_0003, 8'd3,   8'd0},
    {8'd200, 32'h0000_3FFF, 8'd127, 8'd127},
    {8'd10,  32'h0000_0080, 8'd0,   8'd1}
  };

  int  passCnt = 0;
  int  totalCnt = 0;
  bit  done = 0;
  bit  row16Changed = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    totalCnt++;
    if (act === exp) passCnt++;
    else $display("FAIL %s: actual %h expected %h", tag, act, exp);
  endtask

  task automatic wrOne(input bit toS, input bit toG, input logic [1:0] sel,
                       input int addr, input logic [63:0] data);
    @(negedge clk);
    wrEnS = toS; wrEnG = toG; wrSel = sel; wrAddr = 11'(addr); wrData = data;
  endtask

  task automatic wrDone();
    @(negedge clk);
    wrEnS = 0; wrEnG = 0;
  endtask

  task automatic look(input bit single, input logic [7:0] op, input bit sat);
    @(negedge clk);
    if (single) begin opValidG = 1; opcodeG = op; end
    else        begin opValidS = 1; opcodeS = op; end
    satMode = sat;
    @(negedge clk);
    opValidS = 0; opValidG = 0; satMode = 0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] fastExp(input bit single, input logic [7:0] row);
    if (!single && row == 8'd16 && row16Changed) return 32'h1234_5678;
    return 32'hF000_0000 | 32'(row);
  endfunction

  task automatic checkRes(input string req, input bit single, input bit legal,
                          input logic [7:0] fr, input logic [7:0] sr, input bit sat);
    logic v, il, s, sv;
    logic [7:0] afr, asr;
    logic [31:0] afw, asw, efw, esw;
    logic [8*LW-1:0] ln;
    v = single ? vG : vS;   il = single ? iG : iS;   s = single ? sG : sS;
    sv = single ? svG : svS; afr = single ? frG : frS; asr = single ? srG : srS;
    afw = single ? fwG : fwS; asw = single ? swG : swS; ln = single ? lnG : lnS;
    efw = legal ? fastExp(single, fr) : 32'h0;
    esw = (legal && !single && sr != 0) ? (32'h5000_0000 | 32'(sr)) : 32'h0;
    check({req, " R2 valid"}, 64'(v), 64'(legal));
    check({req, " R2 illegal"}, 64'(il), 64'(!legal));
    check({req, " fast row"}, 64'(afr), legal ? 64'(fr) : 64'h0);
    check({req, " slow row"}, 64'(asr), legal ? 64'(sr) : 64'h0);
    check({req, " R4 slow valid"}, 64'(sv), 64'(legal && sr != 0));
    check({req, " fast word"}, 64'(afw), 64'(efw));
    check({req, " R4 slow word"}, 64'(asw), 64'(esw));
    if (legal) check({req, " R11 sat"}, 64'(s), 64'(sat));
    for (int i = 0; i < 8; i++)
      check({req, " R6 lane"}, 64'(ln[i*LW +: LW]),
            legal ? 64'(32'hD000_0000 | (32'(fr) * 8 + 32'(i))) : 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R10: reset state
    check("R10 valid", 64'(vS), 64'h0);
    check("R10 illegal", 64'(iS | iG), 64'h0);
    check("R10 row", 64'(frS), 64'h0);
    check("R10 word", 64'(fwS), 64'h0);
    look(0, 8'd65, 0);  checkRes("R10 split", 0, 0, 0, 0, 0);
    look(1, 8'd102, 0); checkRes("R10 single", 1, 0, 0, 0, 0);

    // R8: table loads
    for (int r = 0; r < 256; r++)  wrOne(1, 1, 2'd1, r, 64'hF000_0000 | 64'(r));
    for (int r = 0; r < 256; r++)  wrOne(1, 1, 2'd2, r, 64'h5000_0000 | 64'(r));
    for (int a = 0; a < 2048; a++) wrOne(1, 1, 2'd3, a, 64'hD000_0000 | 64'(a));
    for (int k = 0; k < 6; k++) wrOne(1, 0, 2'd0, int'(VEC_S[k][55:48]), 64'(VEC_S[k][47:16]));
    for (int k = 0; k < 4; k++) wrOne(0, 1, 2'd0, int'(VEC_G[k][55:48]), 64'(VEC_G[k][47:16]));
    wrOne(1, 0, 2'd0, 11, 64'hABCD_0000_0000_3010);
    wrOne(1, 0, 2'd0, 9,  64'hFFFF_FFFF_FFFF_0000);
    wrOne(0, 1, 2'd0, 9,  64'h0000_0000_0000_C000);
    wrOne(0, 1, 2'd0, 11, 64'hFFFF_FFFF_FFFF_C9CF);
    wrDone();

    // R1 R3 R4 R6: split vectors
    for (int k = 0; k < 6; k++) begin
      look(0, VEC_S[k][55:48], 0);
      checkRes("R1 R3 split vec", 0, 1, VEC_S[k][15:8], VEC_S[k][7:0], 0);
    end
    // R5: single-table vectors
    for (int k = 0; k < 4; k++) begin
      look(1, VEC_G[k][55:48], 0);
      checkRes("R1 R5 single vec", 1, 1, VEC_G[k][15:8], VEC_G[k][7:0], 0);
    end

    // R2: unloaded opcode
    look(0, 8'd7, 0); checkRes("R2 split", 0, 0, 0, 0, 0);
    look(1, 8'd7, 0); checkRes("R2 single", 1, 0, 0, 0, 0);

    // R8: upper descriptor bits dropped
    look(0, 8'd11, 0); checkRes("R8 split keep", 0, 1, 8'd16, 8'd48, 0);
    look(0, 8'd9, 0);  checkRes("R8 split drop", 0, 0, 0, 0, 0);
    look(1, 8'd9, 0);  checkRes("R8 single drop", 1, 0, 0, 0, 0);
    look(1, 8'd11, 0); checkRes("R8 single keep", 1, 1, 8'd79, 8'd19, 0);

    // R11: mode passthrough
    look(0, 8'd48, 1); checkRes("R11 sat", 0, 1, 8'd8, 8'd0, 1);

    // R7: back-to-back lookups
    @(negedge clk); opValidS = 1; opcodeS = 8'd65;
    @(negedge clk); opcodeS = 8'd48;
    @(negedge clk); opValidS = 0;
    checkRes("R7 first", 0, 1, 8'd16, 8'd48, 0);
    @(negedge clk);
    checkRes("R7 second", 0, 1, 8'd8, 8'd0, 0);
    @(negedge clk);
    check("R7 idle after", 64'(vS | iS), 64'h0);

    // R9: writes on the lookup's read edges see old contents
    @(negedge clk);
    opValidS = 1; opcodeS = 8'd65;
    wrEnS = 1; wrSel = 2'd0; wrAddr = 11'd65; wrData = 64'h5;
    @(negedge clk);
    opValidS = 0;
    wrSel = 2'd1; wrAddr = 11'd16; wrData = 64'h1234_5678;
    @(negedge clk);
    wrEnS = 0;
    checkRes("R9 old", 0, 1, 8'd16, 8'd48, 0);
    row16Changed = 1;
    look(0, 8'd65, 0); checkRes("R9 R8 new desc", 0, 1, 8'd5, 8'd0, 0);
    look(0, 8'd11, 0); checkRes("R9 R8 new row", 0, 1, 8'd16, 8'd48, 0);

    done = 1;
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      totalCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", passCnt, totalCnt);
      $finish;
    end
  end

endmodule